// File: doc/BRIEF.md
# Frame Header Decoder and Buffer Bounds Guard

This block runs once per display frame, before any pixel is fetched. A `start` pulse captures the first palette word of the frame buffer, the panel width and height, the panel-type and mode bits, the size of the selected buffer and the partial-panel register. It works out the pixel depth, the pixel colour format, where the pixel data begins after the palette header, the number of bytes in one line and the range of lines to show. Exactly two cycles after `start` it presents these results together with a one-cycle `done` pulse.

The block owns the controller's enable flag, a sticky sync-error flag, one completion bit per frame buffer and the index of the buffer in use. A frame that would read past the end of its buffer raises the sync error and turns the controller off. A frame that fits marks its buffer complete, can pulse an interrupt and, with two buffers, moves on to the other one. The memory reads and the pixel drawing that follow are outside this block.

Top module: `frame_hdr_check`

## Requirements
- R1: The depth code is `pal0[14:12]`. Code 1 gives `bpp` = 2, code 2 gives 4, code 3 gives 8 and codes 4 to 7 give 16.
- R2: Depth code 0 is unsupported. That frame ends with `done` and `frame_ok` = 0, and the enable flag, the sync-error flag, the buffer bits and the buffer index are left as they were.
- R3: `fmt` is 0 (palette indexed) for depth codes 1 to 3. For codes 4 to 7 it is 1 (12-bit colour) when `tft` = 0 and 2 (16-bit colour) when `tft` = 1.
- R4: When `mode` is 2, `pix_offset` is 0. For any other mode it is 512 for depth codes 3 to 7 and 32 for codes 1 and 2.
- R5: A frame requested while the controller is disabled, or while `mode` is 1, is not processed. It gives `frame_ok` = 0 and changes no state.
- R6: Let width = `width_m1`+1 and height = `height_m1`+1. If `pix_offset` + width*height*bpp/8 (rounded down) is greater than `buf_size`+2, the frame sets `sync_err`, clears `enabled` and gives `frame_ok` = 0. A total equal to `buf_size`+2 is accepted.
- R7: An accepted frame sets `frame_ok`, reports the buffer it used on `buf_sel` and sets bit `buf_sel` of `buf_done`. When `irq_en` is 1 it also pulses `buf_irq` in the `done` cycle.
- R8: After an accepted frame with `dual` = 1 the next frame uses the other buffer. With `dual` = 0 the buffer index stays as it is.
- R9: If `subpanel[31]` = 0, `line_first` = 0 and `line_count` = height. If `subpanel[31]` = 1 and `subpanel[29]` = 1, `line_first` = `subpanel[25:16]` and `line_count` = height. If `subpanel[31]` = 1 and `subpanel[29]` = 0, `line_first` = 0 and `line_count` = `subpanel[25:16]`.
- R10: `stride` = width*bpp/8, rounded down.
- R11: `done` is high for exactly one cycle, two clock edges after the edge that samples `start`. All inputs are captured at the `start` edge.
- R12: `en_set` sets `enabled` and clears `sync_err`, `buf_done` and the buffer index. `en_clr` clears `enabled`.
- R13: After reset, `enabled`, `sync_err`, `done`, `frame_ok`, `buf_irq`, `buf_sel` and `buf_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin decoding one frame |
| en_set | input | 1 | Turn the controller on and clear its frame state |
| en_clr | input | 1 | Turn the controller off |
| mode | input | 2 | Load mode (1: no frames, 2: no palette header) |
| tft | input | 1 | Active-matrix panel |
| dual | input | 1 | Alternate between two buffers |
| irq_en | input | 1 | Interrupt on frame acceptance |
| pal0 | input | 16 | First palette word of the buffer |
| width_m1 | input | XW | Panel width minus one |
| height_m1 | input | XW | Panel height minus one |
| buf_size | input | WB | Selected buffer size in bytes (bottom minus top) |
| subpanel | input | 32 | Partial-panel control word |
| enabled | output | 1 | Controller enable flag |
| sync_err | output | 1 | Sticky frame overrun flag |
| done | output | 1 | Results valid, one-cycle pulse |
| frame_ok | output | 1 | Frame accepted for fetch |
| buf_sel | output | 1 | Buffer used by the accepted frame |
| buf_irq | output | 1 | Buffer completion interrupt pulse |
| buf_done | output | 2 | Sticky completion bit per buffer |
| bpp | output | 5 | Bits per pixel |
| fmt | output | 2 | Pixel format code |
| pix_offset | output | 10 | Byte offset of the pixel data |
| stride | output | XW+2 | Bytes per line |
| line_first | output | XW | First line shown |
| line_count | output | XW+1 | Number of lines shown |

## Verification
On every cycle the assertions check the fixed two-cycle latency of `done`, that the buffer completion bits change only on an accepted frame or on `en_set`, that a rising sync error comes together with a disabled controller and a rejected frame, that any accepted frame reports a legal depth, and that the header-less mode never reports an offset. Only the bench's scenarios can show the arithmetic: the exact overrun boundary at the buffer size plus two, truncated strides at small depths, the three partial-panel cases, buffer alternation across successive frames, and recovery after a sync error.

// File: rtl/frame_hdr_check.sv
module frame_hdr_check #(
  parameter int XW = 10,
  parameter int WB = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic [1:0]    mode,
  input  logic          tft,
  input  logic          dual,
  input  logic          irq_en,
  input  logic [15:0]   pal0,
  input  logic [XW-1:0] width_m1,
  input  logic [XW-1:0] height_m1,
  input  logic [WB-1:0] buf_size,
  input  logic [31:0]   subpanel,
  output logic          enabled,
  output logic          sync_err,
  output logic          done,
  output logic          frame_ok,
  output logic          buf_sel,
  output logic          buf_irq,
  output logic [1:0]    buf_done,
  output logic [4:0]    bpp,
  output logic [1:0]    fmt,
  output logic [9:0]    pix_offset,
  output logic [XW+1:0] stride,
  output logic [XW-1:0] line_first,
  output logic [XW:0]   line_count
);

  localparam int PW = 2 * XW + 6;
  localparam int CW = ((PW > WB) ? PW : WB) + 1;

  logic [2:0] code;
  logic [2:0] lg_c;
  logic [XW:0] w_c, h_c;
  logic [XW-1:0] sp_field;

  assign code     = pal0[14:12];
  assign w_c      = {1'b0, width_m1} + 1'b1;
  assign h_c      = {1'b0, height_m1} + 1'b1;
  assign sp_field = subpanel[16 +: XW];

  always_comb begin
    case (code)
      3'd0:    lg_c = 3'd0;
      3'd1:    lg_c = 3'd1;
      3'd2:    lg_c = 3'd2;
      3'd3:    lg_c = 3'd3;
      default: lg_c = 3'd4;
    endcase
  end

  logic          s1_v, s1_go, s1_dual, s1_irq;
  logic [2:0]    s1_lg;
  logic [1:0]    s1_fmt;
  logic [9:0]    s1_off;
  logic [XW:0]   s1_w, s1_h, s1_cnt;
  logic [XW-1:0] s1_first;
  logic [WB-1:0] s1_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_go    <= 1'b0;
      s1_dual  <= 1'b0;
      s1_irq   <= 1'b0;
      s1_lg    <= '0;
      s1_fmt   <= '0;
      s1_off   <= '0;
      s1_w     <= '0;
      s1_h     <= '0;
      s1_cnt   <= '0;
      s1_first <= '0;
      s1_size  <= '0;
    end else begin
      s1_v <= start;
      if (start) begin
        s1_go   <= (mode != 2'd1) && (code != 3'd0);
        s1_dual <= dual;
        s1_irq  <= irq_en;
        s1_lg   <= lg_c;
        s1_fmt  <= (code >= 3'd4) ? (tft ? 2'd2 : 2'd1) : 2'd0;
        s1_off  <= (mode == 2'd2) ? 10'd0 : ((code >= 3'd3) ? 10'd512 : 10'd32);
        s1_w    <= w_c;
        s1_h    <= h_c;
        s1_size <= buf_size;
        if (subpanel[31] && subpanel[29]) begin
          s1_first <= sp_field;
          s1_cnt   <= h_c;
        end else if (subpanel[31]) begin
          s1_first <= '0;
          s1_cnt   <= {1'b0, sp_field};
        end else begin
          s1_first <= '0;
          s1_cnt   <= h_c;
        end
      end
    end
  end

  logic [2*XW+1:0] px;
  logic [CW-1:0]   need, limit;
  logic [XW+4:0]   stride_c;
  logic            over;

  assign px       = s1_w * s1_h;
  assign need     = ((CW'(px) << s1_lg) >> 3) + CW'(s1_off);
  assign limit    = CW'(s1_size) + CW'(2);
  assign over     = need > limit;
  assign stride_c = ((XW+5)'(s1_w) << s1_lg) >> 3;

  logic cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled    <= 1'b0;
      sync_err   <= 1'b0;
      done       <= 1'b0;
      frame_ok   <= 1'b0;
      buf_sel    <= 1'b0;
      buf_irq    <= 1'b0;
      buf_done   <= '0;
      cur        <= 1'b0;
      bpp        <= '0;
      fmt        <= '0;
      pix_offset <= '0;
      stride     <= '0;
      line_first <= '0;
      line_count <= '0;
    end else begin
      done     <= s1_v;
      frame_ok <= 1'b0;
      buf_irq  <= 1'b0;
      if (en_clr) enabled <= 1'b0;
      if (en_set) begin
        enabled  <= 1'b1;
        sync_err <= 1'b0;
        buf_done <= '0;
        cur      <= 1'b0;
      end
      if (s1_v) begin
        bpp        <= 5'd1 << s1_lg;
        fmt        <= s1_fmt;
        pix_offset <= s1_off;
        stride     <= stride_c[XW+1:0];
        line_first <= s1_first;
        line_count <= s1_cnt;
        if (enabled && s1_go) begin
          if (over) begin
            sync_err <= 1'b1;
            enabled  <= 1'b0;
          end else begin
            frame_ok      <= 1'b1;
            buf_sel       <= cur;
            buf_done[cur] <= 1'b1;
            buf_irq       <= s1_irq;
            if (s1_dual) cur <= ~cur;
          end
        end
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{pal0, subpanel, stride_c};

endmodule

// File: rtl/frame_hdr_check_sva.sv
module frame_hdr_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       en_set,
  input logic [1:0] mode,
  input logic       enabled,
  input logic       sync_err,
  input logic       done,
  input logic       frame_ok,
  input logic [1:0] buf_done,
  input logic [4:0] bpp,
  input logic [9:0] pix_offset
);

  a_r11_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  a_r11_start_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##2 done);

  a_r6_sync_disables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> (!enabled && done && !frame_ok));

  a_r1_depth_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (done && frame_ok) |-> ($onehot(bpp) && bpp != 5'd1));

  a_r7_cond_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_done) |-> ((done && frame_ok) || $past(en_set)));

  a_r4_no_header_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (done && frame_ok && $past(mode, 2) == 2'd2) |-> pix_offset == 10'd0);

endmodule

bind frame_hdr_check frame_hdr_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .en_set(en_set), .mode(mode),
  .enabled(enabled), .sync_err(sync_err), .done(done), .frame_ok(frame_ok),
  .buf_done(buf_done), .bpp(bpp), .pix_offset(pix_offset)
);

// File: tb/test_frame_hdr_check.sv
module test_frame_hdr_check;
  logic clk = 0, rst_n = 0, start = 0, en_set = 0, en_clr = 0;
  logic [1:0] mode = 0;
  logic tft = 0, dual = 0, irq_en = 0;
  logic [15:0] pal0 = 0;
  logic [9:0] width_m1 = 0, height_m1 = 0;
  logic [23:0] buf_size = 0;
  logic [31:0] subpanel = 0;
  logic enabled, sync_err, done, frame_ok, buf_sel, buf_irq;
  logic [1:0] buf_done, fmt;
  logic [4:0] bpp;
  logic [9:0] pix_offset;
  logic [11:0] stride;
  logic [9:0] line_first;
  logic [10:0] line_count;

  frame_hdr_check i_frame_hdr_check (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  bit m_en = 0, m_err = 0, m_cur = 0;
  bit [1:0] m_bd = 0;

  task automatic chk(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_en(bit on);
    @(negedge clk);
    if (on) en_set = 1; else en_clr = 1;
    @(negedge clk);
    en_set = 0; en_clr = 0;
    if (on) begin m_en = 1; m_err = 0; m_bd = 0; m_cur = 0; end
    else m_en = 0;
    chk("R12 enable", enabled, m_en);
    chk("R12 sync clear", sync_err, m_err);
    chk("R12 buf bits", buf_done, m_bd);
  endtask

  function automatic longint need_bytes(bit [1:0] m, bit [2:0] c, int w, int h);
    int lg = (c >= 4) ? 4 : c;
    int off = (m == 2) ? 0 : ((c >= 3) ? 512 : 32);
    return off + ((longint'(w) * h << lg) >> 3);
  endfunction

  task automatic frame(bit [1:0] m, bit t, bit d, bit ie, bit [2:0] c,
                       int w, int h, longint sz, bit [31:0] sp);
    int lg, off, fm, first, cnt;
    bit go, over, ok;
    string tag;
    @(negedge clk);
    mode = m; tft = t; dual = d; irq_en = ie;
    pal0 = 16'(($urandom & 16'h8fff) | (c << 12));
    width_m1 = 10'(w - 1); height_m1 = 10'(h - 1);
    buf_size = 24'(sz); subpanel = sp; start = 1;
    @(negedge clk);
    start = 0;
    chk("R11 no early done", done, 0);
    @(negedge clk);
    lg = (c >= 4) ? 4 : c;
    off = (m == 2) ? 0 : ((c >= 3) ? 512 : 32);
    fm = (c >= 4) ? (t ? 2 : 1) : 0;
    first = (sp[31] && sp[29]) ? int'(sp[25:16]) : 0;
    cnt = (sp[31] && !sp[29]) ? int'(sp[25:16]) : h;
    go = m_en && m != 1 && c != 0;
    over = need_bytes(m, c, w, h) > sz + 2;
    ok = go && !over;
    tag = (c == 0) ? "R2 skip" : (!m_en || m == 1) ? "R5 idle" : over ? "R6 overrun" : "R7 accept";
    chk("R11 done", done, 1);
    chk(tag, frame_ok, ok);
    if (c != 0) begin
      chk("R1 bpp", bpp, 1 << lg);
      chk("R3 fmt", fmt, fm);
      chk("R4 offset", pix_offset, off);
      chk("R10 stride", stride, (w << lg) >> 3);
    end
    chk("R9 first", line_first, first);
    chk("R9 count", line_count, cnt);
    if (go && over) begin m_err = 1; m_en = 0; end
    chk("R6 sync", sync_err, m_err);
    chk("R6 enable", enabled, m_en);
    chk("R7 irq", buf_irq, ok && ie);
    if (ok) begin
      chk("R7 sel", buf_sel, m_cur);
      m_bd[m_cur] = 1;
      if (d) m_cur = ~m_cur;
    end
    chk("R7 buf bits", buf_done, m_bd);
    @(negedge clk);
    chk("R11 one cycle", done, 0);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #45 rst_n = 1;
    @(negedge clk);
    chk("R13 enabled", enabled, 0);
    chk("R13 sync", sync_err, 0);
    chk("R13 done", done, 0);
    chk("R13 ok", frame_ok, 0);
    chk("R13 buf bits", buf_done, 0);
    chk("R13 irq", buf_irq, 0);
    frame(0, 0, 0, 0, 3, 16, 16, 4096, 0);        // R5 disabled
    do_en(1);
    frame(1, 0, 0, 0, 3, 16, 16, 4096, 0);        // R5 mode 1
    frame(0, 0, 0, 1, 0, 16, 16, 4096, 0);        // R2 code 0
    frame(0, 0, 0, 1, 3, 16, 16, 766, 0);         // R6 exact fit
    frame(0, 0, 1, 1, 1, 5, 3, 100, 32'h8000_0000 | (10'd7 << 16));       // R9 height
    frame(2, 1, 1, 0, 5, 3, 4, 30, 32'hA000_0000 | (10'd9 << 16));       // R8 toggle, R9 first
    frame(0, 0, 0, 0, 2, 7, 7, 64, 0);            // R8 stays
    frame(0, 0, 0, 0, 3, 16, 16, 765, 0);         // R6 one over
    frame(0, 0, 0, 0, 3, 16, 16, 4096, 0);        // R5 disabled after error
    do_en(1);
    frame(2, 0, 0, 0, 4, 1024, 1024, 2097150, 0); // R6 largest exact fit
    do_en(0);
    frame(0, 1, 0, 0, 6, 8, 8, 4096, 0);          // R12 cleared enable
    do_en(1);
    for (int i = 0; i < 60; i++) begin
      bit [1:0] m = 2'($urandom_range(0, 3));
      bit [2:0] c = 3'($urandom_range(0, 7));
      int w = $urandom_range(1, 200);
      int h = $urandom_range(1, 200);
      longint nb = need_bytes(m, c, w, h);
      longint sz = nb - 2 + $urandom_range(0, 6) - 3;
      bit [31:0] sp = $urandom;
      if (sz < 0) sz = 0;
      frame(m, 1'($urandom), 1'($urandom), 1'($urandom), c, w, h, sz, sp);
      if (!m_en) do_en(1);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule